// File: doc/BRIEF.md
# Staircase Window Decoder

This block corrects hard-decision bit errors in a stream of square data blocks protected by a staircase code. Each block holds M×M bits. A window of B block slots is kept on chip. Slot 0 is the slot nearest the channel, and slot B-1 holds the oldest block. Every component codeword joins one row of slot k with the matching column of slot k+1. A shortened single-error-correcting binary code protects each codeword. The decoder therefore repairs errors by running a few passes over codewords that overlap.

A new block is taken only when the window is ready. Taking it shifts every slot one place away from the channel and loads the new block into slot 0. The block leaving slot B-1 is emitted as decoded output. The window then runs ITERS iterations. In each iteration, a row pass corrects the row halves of all codewords in the whole window at once. A column pass then corrects the column halves. Syndromes are formed again from the stored bits before each pass. Nothing is carried along with the data. A slot is written only when a correction targets it, and no slot is written when every syndrome is zero.

Top module: `stc_decoder`

## Requirements
- R1: While reset is applied and in the first cycle after it, in_ready is 1 and out_valid is 0.
- R2: A block is accepted on a clock edge where in_valid and in_ready are both 1. After that edge, in_ready stays 0 for exactly 4*ITERS cycles: a syndrome cycle and a correction cycle for each of the two passes of each iteration.
- R3: out_valid is 1 for exactly one cycle after an accepting edge, and only when at least B blocks were accepted before that edge since reset. out_data then holds the decoded contents of the block accepted B acceptances earlier.
- R4: Bit (r,c) of a block is in_data[r*M+c]. Codeword (k,i), for k from 0 to B-2, lists two groups of bits. Positions 0..M-1 are row i of slot k, in order c=0..M-1. Positions M..2M-1 are column i of slot k+1, in order r=0..M-1. Position q below P=clog2(2M+1) has weight 2^q. The remaining positions take, in order, the integers from 3 upward that are not powers of two. A codeword is valid when the XOR of the weights of its one-bits is zero. A stream of valid blocks leaves the decoder unchanged.
- R5: A block that arrives with one flipped bit in any single row leaves the decoder with that bit restored.
- R6: A block that arrives with two flipped bits in the same row leaves the decoder repaired, provided the blocks around it are clean. The column pass repairs it after the block moves to slot 1.
- R7: Each iteration runs the row pass before the column pass. The row pass changes only row halves, so slot B-1 is never written. The column pass changes only column halves, so slot 0 is never written.
- R8: When every registered syndrome is zero, the following correction cycle changes no stored bit.
- R9: While in_ready is 0, in_valid and in_data have no effect on the window or the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | New channel block present |
| in_ready | output | 1 | Window idle and able to shift in a block |
| in_data | input | M*M | Channel block, bit (r,c) at r*M+c |
| out_valid | output | 1 | Decoded block present for one cycle |
| out_data | output | M*M | Decoded block leaving the window |

## Verification
The hardest case to reach is a repair that only a column pass can make. A row with two errors is beyond the row code, so the fix has to come from the slot-1 column codewords after a shift. Those codewords must not also see errors from the newer block. The stimulus table places a double-error row right before a clean block and places single-error blocks elsewhere. The decoded stream can only come out clean if the row passes leave column-half errors alone and the column passes repair them one shift later. During the last sends, junk with in_valid high is driven while in_ready is low, so any wrongly accepted block would shift the stream out of line.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_SYN   = 2'd1,
    ST_FIX   = 2'd2
  } stc_state_t;

  // Weight of codeword position q for a code with p syndrome bits.
  // Low positions carry unit vectors; the rest take non-powers of two.
  function automatic int cw_label(input int q, input int p);
    int res;
    int cnt;
    res = 0;
    cnt = 0;
    if (q < p) begin
      res = 1 << q;
    end else begin
      for (int v = 3; v < (1 << p); v++) begin
        if ((v & (v - 1)) != 0) begin
          if (cnt == q - p) res = v;
          cnt++;
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/stc_syn.sv
module stc_syn #(
  parameter int M = 8,
  parameter int P = 5
) (
  input  logic [M-1:0] row_bits,
  input  logic [M-1:0] col_bits,
  output logic [P-1:0] syn
);

  always_comb begin
    syn = '0;
    for (int q = 0; q < M; q++) begin
      if (row_bits[q]) syn = syn ^ P'(stc_pkg::cw_label(q, P));
      if (col_bits[q]) syn = syn ^ P'(stc_pkg::cw_label(M + q, P));
    end
  end

endmodule

// File: rtl/stc_loc.sv
module stc_loc #(
  parameter int M = 8,
  parameter int P = 5
) (
  input  logic [P-1:0] syn,
  output logic [M-1:0] row_flip,
  output logic [M-1:0] col_flip
);

  for (genvar q = 0; q < M; q++) begin : g_pos
    localparam logic [P-1:0] LROW = P'(stc_pkg::cw_label(q, P));
    localparam logic [P-1:0] LCOL = P'(stc_pkg::cw_label(M + q, P));
    assign row_flip[q] = (syn == LROW);
    assign col_flip[q] = (syn == LCOL);
  end

endmodule

// File: rtl/stc_ctrl.sv
module stc_ctrl #(
  parameter int ITERS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic syn_en,
  output logic fix_en,
  output logic col_phase
);

  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;

  stc_pkg::stc_state_t st;
  logic [IW-1:0]       iter;

  assign in_ready = (st == stc_pkg::ST_READY);
  assign accept   = in_ready && in_valid;
  assign syn_en   = (st == stc_pkg::ST_SYN);
  assign fix_en   = (st == stc_pkg::ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= stc_pkg::ST_READY;
      iter      <= '0;
      col_phase <= 1'b0;
    end else begin
      case (st)
        stc_pkg::ST_READY: begin
          if (accept) begin
            st        <= stc_pkg::ST_SYN;
            iter      <= '0;
            col_phase <= 1'b0;
          end
        end
        stc_pkg::ST_SYN: st <= stc_pkg::ST_FIX;
        stc_pkg::ST_FIX: begin
          if (!col_phase) begin
            col_phase <= 1'b1;
            st        <= stc_pkg::ST_SYN;
          end else if (iter == IW'(ITERS - 1)) begin
            st <= stc_pkg::ST_READY;
          end else begin
            iter      <= iter + 1'b1;
            col_phase <= 1'b0;
            st        <= stc_pkg::ST_SYN;
          end
        end
        default: st <= stc_pkg::ST_READY;
      endcase
    end
  end

endmodule

// File: rtl/stc_decoder.sv
module stc_decoder #(
  parameter int M     = 8,
  parameter int B     = 3,
  parameter int ITERS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [M*M-1:0] in_data,
  output logic           out_valid,
  output logic [M*M-1:0] out_data
);

  localparam int BW = M * M;
  localparam int P  = $clog2(2 * M + 1);
  localparam int NC = B - 1;
  localparam int FW = $clog2(B + 1);

  logic [B-1:0][BW-1:0]         win;
  logic [B-1:0][BW-1:0]         flip;
  logic [B-1:0]                 wr_en;
  logic [NC-1:0][M-1:0][P-1:0]  syn_d;
  logic [NC-1:0][M-1:0][P-1:0]  syn_q;
  logic [NC-1:0][M-1:0][M-1:0]  rf_all;
  logic [NC-1:0][M-1:0][M-1:0]  cf_all;
  logic [FW-1:0]                fill;
  logic                         accept;
  logic                         syn_en;
  logic                         fix_en;
  logic                         col_phase;
  logic                         syn_any;

  stc_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .syn_en    (syn_en),
    .fix_en    (fix_en),
    .col_phase (col_phase)
  );

  // One syndrome unit and one locator per codeword (k,i).
  for (genvar k = 0; k < NC; k++) begin : g_pair
    for (genvar i = 0; i < M; i++) begin : g_cw
      logic [M-1:0] colv;
      for (genvar r = 0; r < M; r++) begin : g_col
        assign colv[r] = win[k+1][r*M+i];
      end
      stc_syn #(.M(M), .P(P)) u_syn (
        .row_bits (win[k][i*M +: M]),
        .col_bits (colv),
        .syn      (syn_d[k][i])
      );
      stc_loc #(.M(M), .P(P)) u_loc (
        .syn      (syn_q[k][i]),
        .row_flip (rf_all[k][i]),
        .col_flip (cf_all[k][i])
      );
    end
  end

  assign syn_any = |syn_q;

  // Row pass touches row halves (slots 0..B-2), column pass column halves.
  always_comb begin
    flip = '0;
    for (int k = 0; k < NC; k++) begin
      for (int i = 0; i < M; i++) begin
        for (int r = 0; r < M; r++) begin
          if (!col_phase) flip[k][i*M+r]   = rf_all[k][i][r];
          else            flip[k+1][r*M+i] = cf_all[k][i][r];
        end
      end
    end
  end

  // Per-slot write enable: a slot is only clocked when a fix lands in it.
  for (genvar k = 0; k < B; k++) begin : g_we
    assign wr_en[k] = fix_en && (|flip[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win       <= '0;
      syn_q     <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        win[0] <= in_data;
        for (int k = 1; k < B; k++) win[k] <= win[k-1];
        out_data  <= win[B-1];
        out_valid <= (fill == FW'(B));
        if (fill != FW'(B)) fill <= fill + 1'b1;
      end else begin
        for (int k = 0; k < B; k++) begin
          if (wr_en[k]) win[k] <= win[k] ^ flip[k];
        end
      end
      if (syn_en) syn_q <= syn_d;
    end
  end

endmodule

// File: rtl/stc_decoder_chk.sv
module stc_decoder_chk #(
  parameter int M = 8,
  parameter int B = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   fix_en,
  input logic                   col_phase,
  input logic                   syn_any,
  input logic [B-1:0][M*M-1:0]  win
);

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_OUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R3

  AST_OUT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready)); // R3

  AST_ROW_PASS_KEEPS_OLDEST: assert property (@(posedge clk) disable iff (rst)
    (fix_en && !col_phase) |=> $stable(win[B-1])); // R7

  AST_COL_PASS_KEEPS_NEWEST: assert property (@(posedge clk) disable iff (rst)
    (fix_en && col_phase) |=> $stable(win[0])); // R7

  AST_CLEAN_ARRAY_HELD: assert property (@(posedge clk) disable iff (rst)
    (fix_en && !syn_any) |=> $stable(win)); // R8

  AST_BUSY_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !fix_en) |=> $stable(win)); // R9

endmodule

bind stc_decoder stc_decoder_chk #(.M(M), .B(B)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .fix_en    (fix_en),
  .col_phase (col_phase),
  .syn_any   (syn_any),
  .win       (win)
);

// File: tb/stc_decoder_tb.sv
`timescale 1ns/1ps
module stc_decoder_tb;

  localparam int M     = 8;
  localparam int B     = 3;
  localparam int ITERS = 2;
  localparam int BW    = M * M;
  localparam int P     = $clog2(2 * M + 1);
  localparam int NV    = 12;

  // {kind, row, col1, col2}; kind 0 clean, 1 one flip, 2 two flips in a row
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h1230, 16'h1700, 16'h2125, 16'h0000, 16'h1070,
    16'h1440, 16'h2607, 16'h0000, 16'h0000, 16'h0000, 16'h0000
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_data = '0;
  logic          out_valid;
  logic [BW-1:0] out_data;

  int total = 0;
  int fails = 0;
  logic [31:0] lf = 32'h1234_5679;
  logic [BW-1:0] clean [NV];

  always #10 clk = ~clk;

  stc_decoder #(.M(M), .B(B), .ITERS(ITERS)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wt(input int q);
    int n;
    int res;
    if (q < P) return 1 << q;
    n = q - P;
    res = 0;
    for (int v = 3; v < 64; v++) begin
      if ((v & (v - 1)) != 0) begin
        if (n == 0 && res == 0) res = v;
        n--;
      end
    end
    return res;
  endfunction

  function automatic logic rbit();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf[7];
  endfunction

  function automatic logic [BW-1:0] encode(input logic [BW-1:0] prev);
    logic [BW-1:0] b;
    int s;
    b = '0;
    for (int i = 0; i < M; i++) begin
      s = 0;
      for (int q = P; q < M; q++) begin
        b[i*M+q] = rbit();
        if (b[i*M+q]) s = s ^ wt(q);
      end
      for (int r = 0; r < M; r++) if (prev[r*M+i]) s = s ^ wt(M + r);
      for (int q = 0; q < P; q++) b[i*M+q] = s[q];
    end
    return b;
  endfunction

  // Caller stands at a negedge. Returns at the negedge where in_ready is 1.
  task automatic send(input logic [BW-1:0] d, input logic exp_v,
                      input logic [BW-1:0] exp_d, input string tag,
                      input logic junk);
    int cnt;
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == exp_v, {"R3 ", tag, " valid"}, BW'(out_valid), BW'(exp_v));
    if (exp_v) chk(out_data == exp_d, {tag, " data"}, out_data, exp_d);
    if (junk) begin
      in_data  = ~d;
      in_valid = 1'b1;
    end else begin
      in_valid = 1'b0;
    end
    cnt = 0;
    while (!in_ready) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 4 * ITERS, "R2 busy cycles", BW'(cnt), BW'(4 * ITERS));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [BW-1:0] prev;
    logic [BW-1:0] tx;
    string tag;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", BW'(in_ready), BW'(1));
    chk(out_valid == 1'b0, "R1 valid in reset", BW'(out_valid), BW'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
        BW'({in_ready, out_valid}), BW'(2'b10));

    prev = '0;
    for (int n = 0; n < NV; n++) begin
      clean[n] = encode(prev);
      prev = clean[n];
      tx = clean[n];
      if (VEC[n][15:12] != 0) tx[VEC[n][11:8]*M + VEC[n][7:4]] ^= 1'b1;
      if (VEC[n][15:12] == 2) tx[VEC[n][11:8]*M + VEC[n][3:0]] ^= 1'b1;
      if (n >= B) begin
        case (VEC[n-B][15:12])
          4'd1:    tag = "R5 single fix";
          4'd2:    tag = "R6 R7 column repair";
          default: tag = "R4 R8 clean pass";
        endcase
        if (n >= 9) tag = {"R9 busy junk ignored ", tag};
      end else begin
        tag = "R3 fill no output";
      end
      send(tx, n >= B, (n >= B) ? clean[n-B] : '0, tag, n >= 8);
    end
    in_valid = 1'b0;

    // Reset in the middle of a full window clears the fill state.
    rst = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 re-reset",
        BW'({in_ready, out_valid}), BW'(2'b10));
    rst = 1'b0;
    @(negedge clk);
    send(encode('0), 1'b0, '0, "R3 no output after re-reset", 1'b0);
    in_valid = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule